// File: doc/BRIEF.md
# Three-Channel Timer Host Interface and Command Decoder

This block sits between a host bus and three timer channels. The host side is an 8-bit data bus, a 2-bit address, an active-low select and active-low read and write strobes, all sampled on the system clock. Each access goes to one of three counter channels or to the control address. The control address accepts writes only. Every byte written there is sorted into one of three commands:
- a mode and format word for one channel,
- a count-latch request for one channel,
- a read-back request.

The block turns each completed access into a single-cycle strobe aimed at the right channel. It also keeps each channel's stored mode, number base and byte format. It tracks each channel's write and read byte pointers, and it selects the byte of the channel's 16-bit count value that a host read returns.

An access FSM has three states: `BUS_IDLE`, `BUS_WRITE` and `BUS_READ`. Its transitions are:
- IDLE to WRITE when select and write are low and read is high.
- IDLE to READ when select and read are low and write is high.
- WRITE to IDLE when write rises (commit) or select rises (abort).
- READ to IDLE when read rises (commit) or select rises (abort).

Each channel keeps two byte-pointer machines, one for writes and one for reads. Each has the states `PTR_LOW` and `PTR_HIGH`. A pointer moves from LOW to HIGH and back on each access in low-then-high format. A mode word sends both pointers to LOW.

Top module: `timer_host_if`

## Requirements
- R1: A committed write to address 0, 1 or 2 strobes only that channel's byte-write output, and `wr_byte` carries the written data.
- R2: Strobes are acted on only while `cs_n` is low. If `cs_n` rises before the strobe does, the access is dropped and no output pulse appears.
- R3: An access is committed once, on the first clock edge that samples its strobe high. The resulting pulse is high for exactly the one following cycle, however long the strobe was held.
- R4: A write to address 3 with select bits [7:6] equal to 0, 1 or 2 and format bits [5:4] not 00 pulses `prog_stb` for that channel. It also stores mode = bits [3:1], BCD = bit 0 and format = bits [5:4] in that channel's configuration outputs.
- R5: A write to address 3 with format bits 00 pulses `latch_stb` for the selected channel. It leaves that channel's stored format, mode, BCD and byte pointers unchanged.
- R6: A write to address 3 with bits [7:6] = 11 pulses only `rb_stb`, with `rb_cnt` = NOT bit 5, `rb_sts` = NOT bit 4 and `rb_sel` = bits [3:1], where bit 1 is channel 0.
- R7: Format 01 sends every data write to the low byte and format 10 sends every data write to the high byte. Format 11 alternates low, high, low, and so on, starting with the low byte.
- R8: A counter read drives `dout_en` high and `dout` with the byte of `cnt_value` picked by the channel's format. Format 01 gives bits [7:0] and format 10 gives bits [15:8]. Format 11 alternates, starting low. The read pointer moves independently of the write pointer.
- R9: A mode word returns both byte pointers of its channel to the low byte.
- R10: A read at address 3 keeps `dout_en` low, shows `READ_FILL` on `dout` and produces no read strobe.
- R11: After reset every channel has format 01, mode 0 and BCD 0, all strobes are low and `dout_en` is low.
- R12: If read and write fall together while idle, neither access is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Target: 0 to 2 for a channel, 3 for control |
| din | input | 8 | Write data from the host |
| cnt_value | input | 48 | Current 16-bit count value of each channel, channel 0 lowest |
| dout | output | 8 | Read data to the host |
| dout_en | output | 1 | High while `dout` carries channel data |
| prog_stb | output | 3 | Per-channel mode word pulse |
| cfg_mode | output | 9 | Stored 3-bit mode per channel |
| cfg_bcd | output | 3 | Stored number-base bit per channel |
| cfg_fmt | output | 6 | Stored 2-bit byte format per channel |
| latch_stb | output | 3 | Per-channel count-latch pulse |
| wr_lo_stb | output | 3 | Per-channel low-byte write pulse |
| wr_hi_stb | output | 3 | Per-channel high-byte write pulse |
| wr_byte | output | 8 | Data byte that goes with a write pulse |
| rd_stb | output | 3 | Per-channel read-complete pulse |
| rb_stb | output | 1 | Read-back command pulse |
| rb_cnt | output | 1 | Read-back asks for count latching |
| rb_sts | output | 1 | Read-back asks for status latching |
| rb_sel | output | 3 | Read-back channel mask |

## Verification
The hardest state to reach is a channel whose write and read pointers point at different bytes while a latch command arrives between them. That state shows whether latching leaves the pointers and format alone, and whether reads and writes advance separately. The stimulus first programs low-then-high format and then leaves the write pointer on the high byte. It then issues a latch and interleaves reads with a further write. Each following byte strobe and read value exposes where the pointers stand. Aborted accesses, rising select before the strobe, and read and write falling together are each produced on purpose. After each one, a normal access confirms that nothing was acted on.

// File: rtl/timer_host_pkg.sv
package timer_host_pkg;

    localparam int ADDR_W = 2;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } bus_state_t;

    typedef enum logic {
        PTR_LOW  = 1'b0,
        PTR_HIGH = 1'b1
    } byte_ptr_t;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_PROG     = 2'd1,
        CMD_LATCH    = 2'd2,
        CMD_READBACK = 2'd3
    } cmd_kind_t;

    localparam logic [1:0] FMT_LATCH = 2'b00;
    localparam logic [1:0] FMT_LO    = 2'b01;
    localparam logic [1:0] FMT_HI    = 2'b10;
    localparam logic [1:0] FMT_LOHI  = 2'b11;

    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] fmt;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_byte_t;

endpackage

// File: rtl/timer_host_bus_fsm.sv
module timer_host_bus_fsm
    import timer_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    output logic              wr_commit,
    output logic              rd_commit,
    output logic              rd_active,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [BYTE_W-1:0] acc_data
);

    bus_state_t state_q;
    bus_state_t state_d;
    logic       wr_done;
    logic       rd_done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (!cs_n && !wr_n && rd_n) begin
                    state_d = BUS_WRITE;
                end else if (!cs_n && !rd_n && wr_n) begin
                    state_d = BUS_READ;
                end
            end
            BUS_WRITE: begin
                if (cs_n || wr_n) begin
                    state_d = BUS_IDLE;
                end
            end
            BUS_READ: begin
                if (cs_n || rd_n) begin
                    state_d = BUS_IDLE;
                end
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign wr_done   = (state_q == BUS_WRITE) && !cs_n && wr_n;
    assign rd_done   = (state_q == BUS_READ) && !cs_n && rd_n;
    assign rd_active = (state_q == BUS_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_commit <= 1'b0;
            rd_commit <= 1'b0;
            acc_addr  <= '0;
            acc_data  <= '0;
        end else begin
            wr_commit <= wr_done;
            rd_commit <= rd_done;
            if ((state_q == BUS_IDLE) && (state_d != BUS_IDLE)) begin
                acc_addr <= addr;
            end
            if (state_d == BUS_WRITE) begin
                acc_data <= din;
            end
        end
    end

    // R3
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R3
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_commit |=> !rd_commit);

    // R2
    wr_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(!cs_n && wr_n));

    // R12
    both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_IDLE && !cs_n && !rd_n && !wr_n) |=> (state_q == BUS_IDLE));

endmodule

// File: rtl/timer_host_cmd_dec.sv
module timer_host_cmd_dec
    import timer_host_pkg::*;
#(
    parameter int NCH = 3
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [BYTE_W-1:0] acc_data,
    output logic [NCH-1:0]    prog,
    output logic [NCH-1:0]    latch,
    output logic [NCH-1:0]    cnt_wr,
    output logic [1:0]        new_fmt,
    output logic [2:0]        new_mode,
    output logic              new_bcd,
    output logic              rb_stb,
    output logic              rb_cnt,
    output logic              rb_sts,
    output logic [2:0]        rb_sel
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

    ctrl_byte_t cb;
    cmd_kind_t  kind;
    logic       is_ctrl;

    assign cb      = ctrl_byte_t'(acc_data);
    assign is_ctrl = wr_commit && (acc_addr == CTRL_ADDR);

    always_comb begin
        if (!is_ctrl) begin
            kind = CMD_NONE;
        end else if (cb.sel == 2'b11) begin
            kind = CMD_READBACK;
        end else if (int'(cb.sel) >= NCH) begin
            kind = CMD_NONE;
        end else if (cb.fmt == FMT_LATCH) begin
            kind = CMD_LATCH;
        end else begin
            kind = CMD_PROG;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign prog[c]   = (kind == CMD_PROG)  && (cb.sel == 2'(c));
        assign latch[c]  = (kind == CMD_LATCH) && (cb.sel == 2'(c));
        assign cnt_wr[c] = wr_commit && (acc_addr == ADDR_W'(c));
    end

    assign new_fmt  = cb.fmt;
    assign new_mode = cb.mode;
    assign new_bcd  = cb.bcd;

    assign rb_stb = (kind == CMD_READBACK);
    assign rb_cnt = rb_stb && !acc_data[5];
    assign rb_sts = rb_stb && !acc_data[4];
    assign rb_sel = rb_stb ? acc_data[3:1] : 3'b000;

    // R6
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rb_stb, |prog, |latch, |cnt_wr}));

    // R4
    prog_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|prog) |-> (acc_data[5:4] != 2'b00 && acc_addr == CTRL_ADDR));

endmodule

// File: rtl/timer_host_chan_seq.sv
module timer_host_chan_seq
    import timer_host_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog,
    input  logic                wr_acc,
    input  logic                rd_acc,
    input  logic [1:0]          fmt_in,
    input  logic [2:0]          mode_in,
    input  logic                bcd_in,
    input  logic [2*BYTE_W-1:0] cnt_value,
    output logic [1:0]          cfg_fmt,
    output logic [2:0]          cfg_mode,
    output logic                cfg_bcd,
    output logic                wr_lo,
    output logic                wr_hi,
    output logic [BYTE_W-1:0]   rd_byte
);

    byte_ptr_t wr_ptr_q, wr_ptr_d;
    byte_ptr_t rd_ptr_q, rd_ptr_d;
    logic      rd_sel_hi;

    always_comb begin
        wr_ptr_d = wr_ptr_q;
        rd_ptr_d = rd_ptr_q;
        if (prog) begin
            wr_ptr_d = PTR_LOW;
            rd_ptr_d = PTR_LOW;
        end else begin
            if (wr_acc && cfg_fmt == FMT_LOHI) begin
                unique case (wr_ptr_q)
                    PTR_LOW:  wr_ptr_d = PTR_HIGH;
                    PTR_HIGH: wr_ptr_d = PTR_LOW;
                    default:  wr_ptr_d = PTR_LOW;
                endcase
            end
            if (rd_acc && cfg_fmt == FMT_LOHI) begin
                unique case (rd_ptr_q)
                    PTR_LOW:  rd_ptr_d = PTR_HIGH;
                    PTR_HIGH: rd_ptr_d = PTR_LOW;
                    default:  rd_ptr_d = PTR_LOW;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= PTR_LOW;
            rd_ptr_q <= PTR_LOW;
        end else begin
            wr_ptr_q <= wr_ptr_d;
            rd_ptr_q <= rd_ptr_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_fmt  <= FMT_LO;
            cfg_mode <= 3'd0;
            cfg_bcd  <= 1'b0;
        end else if (prog) begin
            cfg_fmt  <= fmt_in;
            cfg_mode <= mode_in;
            cfg_bcd  <= bcd_in;
        end
    end

    always_comb begin
        wr_lo = 1'b0;
        wr_hi = 1'b0;
        if (wr_acc) begin
            unique case (cfg_fmt)
                FMT_LO:   wr_lo = 1'b1;
                FMT_HI:   wr_hi = 1'b1;
                FMT_LOHI: begin
                    wr_lo = (wr_ptr_q == PTR_LOW);
                    wr_hi = (wr_ptr_q == PTR_HIGH);
                end
                default: ;
            endcase
        end
    end

    assign rd_sel_hi = (cfg_fmt == FMT_HI) ||
                       (cfg_fmt == FMT_LOHI && rd_ptr_q == PTR_HIGH);
    assign rd_byte   = rd_sel_hi ? cnt_value[2*BYTE_W-1:BYTE_W] : cnt_value[BYTE_W-1:0];

    // R9
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> (wr_ptr_q == PTR_LOW && rd_ptr_q == PTR_LOW));

    // R7
    byte_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo && wr_hi));

    // R7
    lohi_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && cfg_fmt == FMT_LOHI) |=> (wr_ptr_q != $past(wr_ptr_q)));

endmodule

// File: rtl/timer_host_if.sv
module timer_host_if
    import timer_host_pkg::*;
#(
    parameter int          NCH       = 3,
    parameter logic [7:0]  READ_FILL = 8'hFF
)
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [1:0]           addr,
    input  logic [7:0]           din,
    input  logic [NCH*16-1:0]    cnt_value,
    output logic [7:0]           dout,
    output logic                 dout_en,
    output logic [NCH-1:0]       prog_stb,
    output logic [NCH*3-1:0]     cfg_mode,
    output logic [NCH-1:0]       cfg_bcd,
    output logic [NCH*2-1:0]     cfg_fmt,
    output logic [NCH-1:0]       latch_stb,
    output logic [NCH-1:0]       wr_lo_stb,
    output logic [NCH-1:0]       wr_hi_stb,
    output logic [7:0]           wr_byte,
    output logic [NCH-1:0]       rd_stb,
    output logic                 rb_stb,
    output logic                 rb_cnt,
    output logic                 rb_sts,
    output logic [2:0]           rb_sel
);

    localparam int CW = 2 * BYTE_W;

    logic              wr_commit;
    logic              rd_commit;
    logic              rd_active;
    logic [ADDR_W-1:0] acc_addr;
    logic [BYTE_W-1:0] acc_data;
    logic [NCH-1:0]    cnt_wr;
    logic [1:0]        new_fmt;
    logic [2:0]        new_mode;
    logic              new_bcd;
    logic [BYTE_W-1:0] rd_byte_arr [NCH];

    timer_host_bus_fsm i_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .din       (din),
        .wr_commit (wr_commit),
        .rd_commit (rd_commit),
        .rd_active (rd_active),
        .acc_addr  (acc_addr),
        .acc_data  (acc_data)
    );

    timer_host_cmd_dec #(.NCH(NCH)) i_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_commit (wr_commit),
        .acc_addr  (acc_addr),
        .acc_data  (acc_data),
        .prog      (prog_stb),
        .latch     (latch_stb),
        .cnt_wr    (cnt_wr),
        .new_fmt   (new_fmt),
        .new_mode  (new_mode),
        .new_bcd   (new_bcd),
        .rb_stb    (rb_stb),
        .rb_cnt    (rb_cnt),
        .rb_sts    (rb_sts),
        .rb_sel    (rb_sel)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic rd_acc;
        assign rd_acc    = rd_commit && (acc_addr == ADDR_W'(c));
        assign rd_stb[c] = rd_acc;

        timer_host_chan_seq i_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .prog      (prog_stb[c]),
            .wr_acc    (cnt_wr[c]),
            .rd_acc    (rd_acc),
            .fmt_in    (new_fmt),
            .mode_in   (new_mode),
            .bcd_in    (new_bcd),
            .cnt_value (cnt_value[c*CW +: CW]),
            .cfg_fmt   (cfg_fmt[c*2 +: 2]),
            .cfg_mode  (cfg_mode[c*3 +: 3]),
            .cfg_bcd   (cfg_bcd[c]),
            .wr_lo     (wr_lo_stb[c]),
            .wr_hi     (wr_hi_stb[c]),
            .rd_byte   (rd_byte_arr[c])
        );

        // R5
        latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            latch_stb[c] |=> ($stable(cfg_fmt[c*2 +: 2]) && $stable(cfg_mode[c*3 +: 3])
                              && $stable(cfg_bcd[c])));
    end

    assign wr_byte = acc_data;

    always_comb begin
        dout    = READ_FILL;
        dout_en = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (rd_active && acc_addr == ADDR_W'(c)) begin
                dout    = rd_byte_arr[c];
                dout_en = 1'b1;
            end
        end
    end

    // R8
    drive_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> $past(!cs_n && !rd_n));

endmodule

// File: tb/test_timer_host_if.sv
module test_timer_host_if;

    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              rd_n = 1'b1;
    logic              wr_n = 1'b1;
    logic [1:0]        addr = 2'd0;
    logic [7:0]        din = 8'd0;
    logic [NCH*16-1:0] cnt_value = {16'hE5F6, 16'hC3D4, 16'hA1B2};
    logic [7:0]        dout;
    logic              dout_en;
    logic [NCH-1:0]    prog_stb, cfg_bcd, latch_stb, wr_lo_stb, wr_hi_stb, rd_stb;
    logic [NCH*3-1:0]  cfg_mode;
    logic [NCH*2-1:0]  cfg_fmt;
    logic [7:0]        wr_byte;
    logic              rb_stb, rb_cnt, rb_sts;
    logic [2:0]        rb_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0] prog, latch, wlo, whi, rd;
        logic       rb, rbc, rbs;
        logic [2:0] rbsel;
        logic [7:0] wbyte;
        string      req;
    } ev_t;

    ev_t exp_q[$];

    always #2.5 clk = ~clk;

    timer_host_if i_timer_host_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .cnt_value(cnt_value), .dout(dout), .dout_en(dout_en),
        .prog_stb(prog_stb), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd), .cfg_fmt(cfg_fmt),
        .latch_stb(latch_stb), .wr_lo_stb(wr_lo_stb), .wr_hi_stb(wr_hi_stb),
        .wr_byte(wr_byte), .rd_stb(rd_stb), .rb_stb(rb_stb), .rb_cnt(rb_cnt),
        .rb_sts(rb_sts), .rb_sel(rb_sel)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic ev_t blank(input string req);
        ev_t e;
        e.prog = 0; e.latch = 0; e.wlo = 0; e.whi = 0; e.rd = 0;
        e.rb = 0; e.rbc = 0; e.rbs = 0; e.rbsel = 0; e.wbyte = 0; e.req = req;
        return e;
    endfunction

    // scoreboard monitor: every cycle with a pulse consumes one expected item
    always @(posedge clk) begin
        #1;
        if (|{prog_stb, latch_stb, wr_lo_stb, wr_hi_stb, rd_stb, rb_stb}) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected pulse",
                    {prog_stb, latch_stb, wr_lo_stb, wr_hi_stb, rd_stb, rb_stb}, 0);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                chk(prog_stb == e.prog, e.req, "prog_stb", prog_stb, e.prog);
                chk(latch_stb == e.latch, e.req, "latch_stb", latch_stb, e.latch);
                chk(wr_lo_stb == e.wlo, e.req, "wr_lo_stb", wr_lo_stb, e.wlo);
                chk(wr_hi_stb == e.whi, e.req, "wr_hi_stb", wr_hi_stb, e.whi);
                chk(rd_stb == e.rd, e.req, "rd_stb", rd_stb, e.rd);
                chk(rb_stb == e.rb, e.req, "rb_stb", rb_stb, e.rb);
                if ((e.wlo | e.whi) != 0)
                    chk(wr_byte == e.wbyte, e.req, "wr_byte", wr_byte, e.wbyte);
                if (e.rb) begin
                    chk(rb_cnt == e.rbc, e.req, "rb_cnt", rb_cnt, e.rbc);
                    chk(rb_sts == e.rbs, e.req, "rb_sts", rb_sts, e.rbs);
                    chk(rb_sel == e.rbsel, e.req, "rb_sel", rb_sel, e.rbsel);
                end
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input int hold);
        @(negedge clk); addr = a; din = d; cs_n = 0; wr_n = 0;
        repeat (hold) @(negedge clk);
        wr_n = 1;
        @(negedge clk); cs_n = 1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [1:0] a, input logic exp_en,
                            input logic [7:0] exp_d, input string req);
        if (a != 2'd3) begin
            ev_t e;
            e = blank(req);
            e.rd[a] = 1'b1;
            exp_q.push_back(e);
        end
        @(negedge clk); addr = a; cs_n = 0; rd_n = 0;
        @(negedge clk);
        chk(dout_en == exp_en, req, "dout_en", dout_en, exp_en);
        chk(dout == exp_d, req, "dout", dout, exp_d);
        rd_n = 1;
        @(negedge clk); cs_n = 1;
        @(negedge clk);
    endtask

    task automatic exp_data(input int ch, input bit hi, input logic [7:0] d, input string req);
        ev_t e;
        e = blank(req);
        if (hi) e.whi[ch] = 1'b1; else e.wlo[ch] = 1'b1;
        e.wbyte = d;
        exp_q.push_back(e);
    endtask

    task automatic exp_prog(input int ch, input string req);
        ev_t e;
        e = blank(req);
        e.prog[ch] = 1'b1;
        exp_q.push_back(e);
    endtask

    task automatic exp_latch(input int ch, input string req);
        ev_t e;
        e = blank(req);
        e.latch[ch] = 1'b1;
        exp_q.push_back(e);
    endtask

    task automatic exp_rb(input logic c, input logic s, input logic [2:0] sel, input string req);
        ev_t e;
        e = blank(req);
        e.rb = 1'b1; e.rbc = c; e.rbs = s; e.rbsel = sel;
        exp_q.push_back(e);
    endtask

    task automatic chk_cfg(input int ch, input logic [1:0] f, input logic [2:0] m,
                           input logic b, input string req);
        chk(cfg_fmt[ch*2 +: 2] == f, req, "cfg_fmt", cfg_fmt[ch*2 +: 2], f);
        chk(cfg_mode[ch*3 +: 3] == m, req, "cfg_mode", cfg_mode[ch*3 +: 3], m);
        chk(cfg_bcd[ch] == b, req, "cfg_bcd", cfg_bcd[ch], b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", "run ended", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        for (int c = 0; c < NCH; c++) chk_cfg(c, 2'b01, 3'd0, 1'b0, "R11");
        chk(dout_en == 1'b0, "R11", "dout_en", dout_en, 0);

        // R1: channel 1 default low-byte format
        exp_data(1, 0, 8'h34, "R1");
        bus_write(2'd1, 8'h34, 1);

        // R4: channel 0 low-then-high, mode 3, BCD
        exp_prog(0, "R4");
        bus_write(2'd3, 8'h37, 1);
        chk_cfg(0, 2'b11, 3'd3, 1'b1, "R4");

        // R7: alternation
        exp_data(0, 0, 8'h11, "R7");
        bus_write(2'd0, 8'h11, 1);
        exp_data(0, 1, 8'h22, "R7");
        bus_write(2'd0, 8'h22, 1);
        exp_data(0, 0, 8'h33, "R7");
        bus_write(2'd0, 8'h33, 1);

        // R5: latch with write pointer on high byte
        exp_latch(0, "R5");
        bus_write(2'd3, 8'h00, 1);
        chk_cfg(0, 2'b11, 3'd3, 1'b1, "R5");
        exp_data(0, 1, 8'h44, "R5");
        bus_write(2'd0, 8'h44, 1);

        // R8: reads alternate, independent of writes
        bus_read(2'd0, 1'b1, 8'hB2, "R8");
        bus_read(2'd0, 1'b1, 8'hA1, "R8");
        exp_data(0, 0, 8'h55, "R8");
        bus_write(2'd0, 8'h55, 1);
        bus_read(2'd0, 1'b1, 8'hB2, "R8");

        // R8: high-byte format on channel 2
        exp_prog(2, "R4");
        bus_write(2'd3, 8'hA4, 1);
        chk_cfg(2, 2'b10, 3'd2, 1'b0, "R4");
        exp_data(2, 1, 8'h66, "R7");
        bus_write(2'd2, 8'h66, 1);
        bus_read(2'd2, 1'b1, 8'hE5, "R8");
        bus_read(2'd1, 1'b1, 8'hD4, "R8");

        // R9: reprogram with both pointers on high byte
        exp_prog(0, "R9");
        bus_write(2'd3, 8'h30, 1);
        chk_cfg(0, 2'b11, 3'd0, 1'b0, "R9");
        exp_data(0, 0, 8'h77, "R9");
        bus_write(2'd0, 8'h77, 1);
        bus_read(2'd0, 1'b1, 8'hB2, "R9");

        // R6: read-back decode
        exp_rb(1'b1, 1'b0, 3'b011, "R6");
        bus_write(2'd3, 8'hD6, 1);
        exp_rb(1'b0, 1'b1, 3'b101, "R6");
        bus_write(2'd3, 8'hEA, 1);

        // R10: control address read
        bus_read(2'd3, 1'b0, 8'hFF, "R10");

        // R2: select high whole access, then abort
        @(negedge clk); addr = 2'd1; din = 8'h99; wr_n = 0;
        repeat (2) @(negedge clk); wr_n = 1;
        @(negedge clk); cs_n = 0; addr = 2'd1; wr_n = 0;
        @(negedge clk); cs_n = 1;
        @(negedge clk); wr_n = 1;
        repeat (2) @(negedge clk);

        // R12: read and write fall together
        @(negedge clk); cs_n = 0; addr = 2'd1; rd_n = 0; wr_n = 0;
        @(negedge clk);
        chk(dout_en == 1'b0, "R12", "dout_en", dout_en, 0);
        @(negedge clk); rd_n = 1; wr_n = 1;
        @(negedge clk); cs_n = 1;
        repeat (2) @(negedge clk);

        // R3: long strobe gives one pulse
        exp_data(1, 0, 8'h5A, "R3");
        bus_write(2'd1, 8'h5A, 10);

        // R5: latches on channels 1 and 2 keep configuration
        exp_latch(1, "R5");
        bus_write(2'd3, 8'h40, 1);
        chk_cfg(1, 2'b01, 3'd0, 1'b0, "R5");
        exp_latch(2, "R5");
        bus_write(2'd3, 8'h8E, 1);
        chk_cfg(2, 2'b10, 3'd2, 1'b0, "R5");
        exp_data(2, 1, 8'h3C, "R5");
        bus_write(2'd2, 8'h3C, 1);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "missing pulses", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule